// File: doc/BRIEF.md
# I2C Passive Bus Monitor with Event Buffer

The monitor watches the clock and data lines of an I2C bus and never drives either one. Both lines pass through a resynchronising flop chain and are oversampled by the system clock. From that sampled view the block finds start, repeated-start and stop conditions, shifts in the eight data bits of each byte, and takes the ninth bit as the acknowledge. Every bus event becomes one 9-bit entry: a marker bit that says whether the entry is an event symbol or a raw data byte, plus eight value bits.

Entries go into a circular store, 4096 deep by default, that a serial transmitter empties whenever it is free. The transmitter sees a valid/ready stream. If the store is full, a new entry is discarded and older entries stay as they are. A sticky flag records that at least one entry was lost. An exit request ends capture for good, until the next reset. Entries already stored can still be drained after that. Turning bytes into printable hex is left to whatever sits behind the stream. With the default two-flop chain, a system clock of 10 MHz or more gives enough samples per phase for 100 kHz bus traffic.

Top module: `i2c_snf_top`

## Requirements
- R1: After reset, `tx_valid_o` and `overflow_o` are 0 and `capturing_o` is 1; `scl_i` and `sda_i` are inputs only.
- R2: A fall of SDA while SCL is high stores a symbol entry (`tx_sym_o`=1) with value 0x5B. A repeated start inside a frame also stores 0x5B and throws away any partly received bits.
- R3: A rise of SDA while SCL is high stores a symbol entry with value 0x5D and closes the frame.
- R4: Inside a frame, data bits are taken on SCL rising edges, most significant bit first. After the eighth bit the byte is stored as a data entry (`tx_sym_o`=0).
- R5: The ninth SCL rising edge stores a symbol entry. The value is 0x2B when SDA is low (ACK) and 0x2D when SDA is high (NACK).
- R6: SCL rising edges outside a frame, meaning before any start or after a stop, store nothing.
- R7: Entries come out in the order they were stored. While `tx_valid_o` is high and `tx_ready_i` is low, the valid signal and the entry stay unchanged.
- R8: When the store holds its full depth, a new entry is dropped and the stored ones are kept. `overflow_o` then rises and stays high until reset.
- R9: A one-cycle `exit_req_i` pulse clears `capturing_o` on the next cycle and stops all new entries. Entries stored earlier still drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, sampled only |
| sda_i | input | 1 | Bus data line, sampled only |
| exit_req_i | input | 1 | Pulse that ends capture |
| tx_ready_i | input | 1 | Transmitter can take an entry |
| tx_valid_o | output | 1 | An entry is waiting |
| tx_sym_o | output | 1 | 1 = event symbol, 0 = raw data byte |
| tx_data_o | output | 8 | Symbol code or data byte |
| capturing_o | output | 1 | Capture is still running |
| overflow_o | output | 1 | Sticky: an entry was dropped |

## Verification
The bench builds the block with an address width of 4, so the store holds 16 entries, and keeps the default two-stage synchroniser. The small depth means two full three-byte transactions fill the store exactly while the transmitter is held off. A third transaction then shows the drop-newest behaviour and the sticky flag within a few thousand cycles. The store still wraps its pointers several times during the random traffic, so wrap-around order is covered as well.

// File: rtl/i2c_snf_pkg.sv
package i2c_snf_pkg;

  localparam logic [7:0] SYM_START = 8'h5B;
  localparam logic [7:0] SYM_STOP  = 8'h5D;
  localparam logic [7:0] SYM_ACK   = 8'h2B;
  localparam logic [7:0] SYM_NACK  = 8'h2D;

  typedef struct packed {
    logic       is_sym;
    logic [7:0] val;
  } snf_entry_t;

  function automatic logic [7:0] ack_code(input logic sda_bit);
    return sda_bit ? SYM_NACK : SYM_ACK;
  endfunction

  function automatic snf_entry_t mk_sym(input logic [7:0] code);
    return '{is_sym: 1'b1, val: code};
  endfunction

  function automatic snf_entry_t mk_byte(input logic [7:0] b);
    return '{is_sym: 1'b0, val: b};
  endfunction

endpackage

// File: rtl/i2c_snf_sync.sv
module i2c_snf_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '1;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= '1;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/i2c_snf_decode.sv
module i2c_snf_decode
  import i2c_snf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       scl,
  input  logic       sda,
  output logic       push,
  output snf_entry_t entry,
  output logic       ev_start,
  output logic       ev_stop,
  output logic       scl_rise,
  output logic       in_frame
);
  localparam int BITS_PER_BYTE = 8;
  localparam int CW = $clog2(BITS_PER_BYTE + 1);

  logic          scl_q, sda_q, frame_q;
  logic [CW-1:0] bit_cnt;
  logic [BITS_PER_BYTE-1:0] shreg;
  logic          byte_done, ack_slot;

  assign scl_rise  = scl & ~scl_q;
  assign ev_start  = scl & scl_q & sda_q & ~sda;
  assign ev_stop   = scl & scl_q & ~sda_q & sda;
  assign in_frame  = frame_q;
  assign byte_done = scl_rise & frame_q & (bit_cnt == CW'(BITS_PER_BYTE - 1));
  assign ack_slot  = scl_rise & frame_q & (bit_cnt == CW'(BITS_PER_BYTE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      frame_q <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (!enable) begin
        frame_q <= 1'b0;
        bit_cnt <= '0;
      end else if (ev_start) begin
        frame_q <= 1'b1;
        bit_cnt <= '0;
      end else if (ev_stop) begin
        frame_q <= 1'b0;
        bit_cnt <= '0;
      end else if (scl_rise && frame_q) begin
        if (bit_cnt == CW'(BITS_PER_BYTE)) begin
          bit_cnt <= '0;
        end else begin
          shreg   <= {shreg[BITS_PER_BYTE-2:0], sda};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    push  = enable & (ev_start | ev_stop | byte_done | ack_slot);
    entry = mk_sym(SYM_START);
    if (ev_stop)        entry = mk_sym(SYM_STOP);
    else if (byte_done) entry = mk_byte({shreg[BITS_PER_BYTE-2:0], sda});
    else if (ack_slot)  entry = mk_sym(ack_code(sda));
  end

  // R4
  data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !entry.is_sym) |-> in_frame);
endmodule

// File: rtl/i2c_snf_ring.sv
module i2c_snf_ring
  import i2c_snf_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  snf_entry_t wdata,
  input  logic       pop,
  output logic       valid,
  output snf_entry_t rdata,
  output logic       full,
  output logic       ovf
);
  localparam int DEPTH = 1 << AW;

  snf_entry_t    mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          accept, take;

  function automatic logic [AW:0] fill_level(input logic [AW:0] w, input logic [AW:0] r);
    return w - r;
  endfunction

  assign full   = fill_level(wp, rp) == (AW+1)'(DEPTH);
  assign valid  = wp != rp;
  assign accept = push & ~full;
  assign take   = pop & valid;
  assign rdata  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (accept) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      ovf <= 1'b0;
    end else begin
      if (accept)      wp  <= wp + 1'b1;
      if (take)        rp  <= rp + 1'b1;
      if (push & full) ovf <= 1'b1;
    end
  end

  // R8
  drop_keeps_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (wp == $past(wp)));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R7
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pop) |=> (valid && $stable(rdata)));
endmodule

// File: rtl/i2c_snf_top.sv
module i2c_snf_top
  import i2c_snf_pkg::*;
#(
  parameter int AW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       exit_req_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output logic       tx_sym_o,
  output logic [7:0] tx_data_o,
  output logic       capturing_o,
  output logic       overflow_o
);
  logic [1:0] line_s;
  logic       cap_q;
  logic       push, ev_start, ev_stop, scl_rise, in_frame, full;
  snf_entry_t entry, head;

  i2c_snf_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cap_q <= 1'b1;
    else if (exit_req_i) cap_q <= 1'b0;
  end

  i2c_snf_decode u_dec (
    .clk(clk), .rst_n(rst_n), .enable(cap_q),
    .scl(line_s[1]), .sda(line_s[0]),
    .push(push), .entry(entry),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .scl_rise(scl_rise), .in_frame(in_frame)
  );

  i2c_snf_ring #(.AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wdata(entry),
    .pop(tx_ready_i), .valid(tx_valid_o), .rdata(head),
    .full(full), .ovf(overflow_o)
  );

  assign tx_sym_o    = head.is_sym;
  assign tx_data_o   = head.val;
  assign capturing_o = cap_q;

  // R9
  exit_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req_i |=> !capturing_o);
  // R8
  full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overflow_o);
endmodule

// File: tb/i2c_snf_top_tb_top.sv
module i2c_snf_top_tb_top;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1, exit_req = 1'b0;
  logic       tx_ready = 1'b0;
  logic       tx_valid, tx_sym, capturing, overflow;
  logic [7:0] tx_data;

  int n_tests = 0, n_fail = 0, cycles = 0, hold_bad = 0;
  int rdy_mode = 0;
  bit limit_mode = 0, exp_ovf = 0, model_on = 1;
  logic [8:0] exp_q[$];
  logic [8:0] got_q[$];
  bit prev_valid = 0, prev_pop = 0;
  logic [8:0] prev_data = '0;

  always #5 clk = ~clk;

  i2c_snf_top #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .exit_req_i(exit_req), .tx_ready_i(tx_ready),
    .tx_valid_o(tx_valid), .tx_sym_o(tx_sym), .tx_data_o(tx_data),
    .capturing_o(capturing), .overflow_o(overflow)
  );

  function automatic logic [8:0] e_sym(input logic [7:0] c); return {1'b1, c}; endfunction
  function automatic logic [8:0] e_dat(input logic [7:0] b); return {1'b0, b}; endfunction
  function automatic logic [8:0] e_ack(input bit nack); return nack ? 9'h12D : 9'h12B; endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic void add_exp(input logic [8:0] e);
    if (!model_on) return;
    if (limit_mode && exp_q.size() >= DEPTH) exp_ovf = 1;
    else exp_q.push_back(e);
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      tx_ready = (rdy_mode == 0) ? 1'b0 : (($urandom % 3) != 0);
      if (prev_valid && !prev_pop && (!tx_valid || {tx_sym, tx_data} != prev_data)) hold_bad++;
      if (tx_valid && tx_ready) got_q.push_back({tx_sym, tx_data});
      prev_valid = tx_valid;
      prev_pop   = tx_valid && tx_ready;
      prev_data  = {tx_sym, tx_data};
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start();
    if (scl == 1'b0) begin sda = 1'b1; wt(Q); scl = 1'b1; wt(Q); end
    sda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    add_exp(e_sym(8'h5B));
  endtask

  task automatic b_bit(input bit b);
    sda = b; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic b_byte(input logic [7:0] v, input bit nack);
    for (int i = 7; i >= 0; i--) b_bit(v[i]);
    add_exp(e_dat(v));
    b_bit(nack);
    add_exp(e_ack(nack));
  endtask

  task automatic b_stop();
    sda = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda = 1'b1; wt(2*Q);
    add_exp(e_sym(8'h5D));
  endtask

  task automatic drain_cmp(input string req);
    int t = 0;
    while (got_q.size() < exp_q.size() && t < 4000) begin wt(1); t++; end
    wt(40);
    check({req, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(req, got_q[i], exp_q[i]);
    exp_q.delete(); got_q.delete();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    wt(3); rst_n = 1'b1; wt(2);
    // R1 reset state
    check("R1 valid", tx_valid, 0);
    check("R1 overflow", overflow, 0);
    check("R1 capturing", capturing, 1);
    rdy_mode = 1;

    // R6 clocks without a start produce nothing
    scl = 1'b0; wt(Q);
    for (int i = 0; i < 9; i++) b_bit(i[0]);
    sda = 1'b1; wt(Q); scl = 1'b1; wt(4*Q);
    check("R6 idle edges", got_q.size(), 0);

    // R2 R3 R4 R5 directed ACK then NACK
    b_start(); b_byte(8'hA0, 0); b_byte(8'h3C, 1); b_stop();
    drain_cmp("R4/R5 ack-nack");

    // R2 repeated start discards partial bits
    b_start(); b_bit(1); b_bit(0); b_bit(1); b_bit(1);
    b_start(); b_byte(8'h81, 0); b_stop();
    drain_cmp("R2 repeated start");

    // R6 edges after a stop
    scl = 1'b0; wt(Q);
    for (int i = 0; i < 9; i++) b_bit(1'b0);
    sda = 1'b1; wt(Q); scl = 1'b1; wt(4*Q);
    check("R6 after stop", got_q.size(), 0);

    // R7 random traffic, order checked entry by entry
    for (int k = 0; k < 20; k++) begin
      int nb = 1 + ($urandom % 3);
      b_start();
      for (int j = 0; j < nb; j++) begin
        if (($urandom % 4) == 0) b_start();
        b_byte(8'($urandom), bit'($urandom % 2));
      end
      b_stop();
    end
    drain_cmp("R7 random order");
    check("R7 hold while not ready", hold_bad, 0);
    check("R8 no overflow yet", overflow, 0);

    // R8 overflow: transmitter held off
    rdy_mode = 0; limit_mode = 1; wt(4);
    for (int k = 0; k < 3; k++) begin
      b_start();
      b_byte(8'h10 + 8'(k), 0); b_byte(8'h55, 1); b_byte(8'hF0 - 8'(k), 0);
      b_stop();
    end
    check("R8 model dropped", exp_ovf, 1);
    check("R8 overflow flag", overflow, 1);
    rdy_mode = 1; limit_mode = 0;
    drain_cmp("R8 oldest kept");
    check("R8 sticky after drain", overflow, 1);

    // R9 stored entries still drain after exit, nothing new enters
    rdy_mode = 0; wt(4);
    b_start(); b_byte(8'h6E, 0); b_stop();
    @(negedge clk) exit_req = 1'b1;
    @(negedge clk) exit_req = 1'b0;
    check("R9 capturing low", capturing, 0);
    model_on = 0;
    b_start(); b_byte(8'h99, 0); b_stop();
    rdy_mode = 1;
    drain_cmp("R9 drain after exit");
    b_start(); b_byte(8'h42, 1); b_stop();
    wt(40);
    check("R9 no new entries", got_q.size(), 0);
    check("R9 valid low", tx_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule